// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides whether a whole thread block may become resident on it. Each request presents the block's thread count and the number of registers each of its threads needs. The controller holds three running budgets: free block slots, free thread capacity, and free entries in a shared register pool. A block is admitted only when all three budgets can cover it at once. Its register cost is the thread count multiplied by the per-thread register count, carved out of the pool for that block alone.

Requests arrive on a valid/ready channel. A request that fits is accepted at once. One cycle later a response reports the grant and the slot index the block now holds. A request that can never fit is accepted as well, and its response reports a refusal. Such a request has zero threads, more threads than the multiprocessor can hold, or a register cost larger than the whole pool. A request that could fit later is held: ready stays low until a release frees enough. When a block finishes, its slot index on the release port returns that block's threads, registers and slot to the budgets.

Top module: `blk_admit`

## Requirements
- R1: After reset no response and no error flag is raised, all 8 slots, 768 threads and 8192 registers are free, and a 768-thread request at 10 registers per thread shows ready.
- R2: A request is accepted (reqReady high while reqValid high at a clock edge) only when the slot, thread and register checks all pass. The cycle after acceptance, rspValid is high, with rspGrant=1 and the assigned slot on rspSlot.
- R3: The thread counts of all resident blocks never sum above 768. A request whose threads exceed the free thread count is not accepted.
- R4: A block consumes reqThreads × reqRegs entries of the 8192-entry register pool. A request whose cost exceeds the free entries is not accepted.
- R5: At most 8 blocks are resident. With all slots taken, no fitting request is accepted.
- R6: The granted slot is the lowest-numbered slot that is free in the cycle of acceptance.
- R7: A request with zero threads, with more than 768 threads, or with a cost above 8192 is accepted at once and answered with rspValid=1, rspGrant=0. It leaves all budgets unchanged.
- R8: A release (relValid with the slot index on relSlot) of an occupied slot returns exactly that block's threads, registers and slot. A later request needing them can then be accepted.
- R9: A release naming a free slot changes nothing and raises relError for the following cycle.
- R10: A request that cannot fit now sees reqReady low and produces no response for as long as it waits.
- R11: When a release and a request fall in the same cycle, the request is judged on the budgets that stood before that release. The freed resources count from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Admission request present |
| reqReady | output | 1 | Request is taken at this edge |
| reqThreads | input | 11 | Thread count of the requesting block |
| reqRegs | input | 8 | Registers needed per thread |
| rspValid | output | 1 | Response for the request taken last cycle |
| rspGrant | output | 1 | 1 = admitted, 0 = refused as impossible |
| rspSlot | output | 3 | Slot index of an admitted block |
| relValid | input | 1 | Block-complete strobe |
| relSlot | input | 3 | Slot index of the completed block |
| relError | output | 1 | Release named a slot that was not occupied |

## Verification
The hardest state to reach is a release and a waiting request landing in the same cycle, where the answer depends on the ordering rule rather than on the budgets. The bench fills the thread budget, holds a second request pending, and checks that ready is still low while the release is on the port. It then checks that ready rises the cycle after, and that the freed slot 0 is granted. A vector table also reaches each of the three limits on its own. This includes a register-only shortfall, where threads and slots remain, and a ninth block of small size, where threads and registers remain.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  // Strobes from control to datapath, valid for the current clock edge
  typedef struct packed {
    logic doAdmit;
    logic doFree;
  } ctlStrobe_t;
endpackage

// File: rtl/blk_admit_dp.sv
module blk_admit_dp
  import blk_admit_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int MAX_THREADS = 768,
  parameter int REG_POOL    = 8192,
  parameter int REQ_THR_W   = 11,
  parameter int REG_PER_W   = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int POOL_W = $clog2(REG_POOL + 1),
  localparam int COST_W = REQ_THR_W + REG_PER_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           st,
  input  logic [SLOT_W-1:0]    grantSlot,
  input  logic [SLOT_W-1:0]    relSlot,
  input  logic [REQ_THR_W-1:0] reqThreads,
  input  logic [REG_PER_W-1:0] reqRegs,
  output logic [COST_W-1:0]    reqCost,
  output logic [NUM_SLOTS-1:0] busyMask,
  output logic [THR_W-1:0]     freeThreads,
  output logic [POOL_W-1:0]    freeRegs
);
  logic [THR_W-1:0]  thrArr [NUM_SLOTS];
  logic [POOL_W-1:0] regArr [NUM_SLOTS];

  assign reqCost = COST_W'(reqThreads) * COST_W'(reqRegs);

  // Per-slot ledger: what each resident block holds
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    logic              busyQ;
    logic [THR_W-1:0]  thrQ;
    logic [POOL_W-1:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyQ <= 1'b0;
        thrQ  <= '0;
        regQ  <= '0;
      end else if (st.doAdmit && grantSlot == SLOT_W'(i)) begin
        busyQ <= 1'b1;
        thrQ  <= THR_W'(reqThreads);
        regQ  <= POOL_W'(reqCost);
      end else if (st.doFree && relSlot == SLOT_W'(i)) begin
        busyQ <= 1'b0;
      end
    end
    assign busyMask[i] = busyQ;
    assign thrArr[i]   = thrQ;
    assign regArr[i]   = regQ;
  end

  logic [THR_W-1:0]  thrTake, thrGive;
  logic [POOL_W-1:0] regTake, regGive;

  always_comb begin
    thrTake = st.doAdmit ? THR_W'(reqThreads) : '0;
    regTake = st.doAdmit ? POOL_W'(reqCost)   : '0;
    thrGive = st.doFree  ? thrArr[relSlot]    : '0;
    regGive = st.doFree  ? regArr[relSlot]    : '0;
  end

  // Budgets: admission and release settle on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeThreads <= THR_W'(MAX_THREADS);
      freeRegs    <= POOL_W'(REG_POOL);
    end else begin
      freeThreads <= freeThreads - thrTake + thrGive;
      freeRegs    <= freeRegs - regTake + regGive;
    end
  end
endmodule

// File: rtl/blk_admit_ctl.sv
module blk_admit_ctl
  import blk_admit_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int MAX_THREADS = 768,
  parameter int REG_POOL    = 8192,
  parameter int REQ_THR_W   = 11,
  parameter int REG_PER_W   = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int POOL_W = $clog2(REG_POOL + 1),
  localparam int COST_W = REQ_THR_W + REG_PER_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [REQ_THR_W-1:0] reqThreads,
  input  logic [COST_W-1:0]    reqCost,
  input  logic                 relValid,
  input  logic [SLOT_W-1:0]    relSlot,
  input  logic [NUM_SLOTS-1:0] busyMask,
  input  logic [THR_W-1:0]     freeThreads,
  input  logic [POOL_W-1:0]    freeRegs,
  output logic                 reqReady,
  output ctlStrobe_t           st,
  output logic [SLOT_W-1:0]    grantSlot,
  output logic                 rspValid,
  output logic                 rspGrant,
  output logic [SLOT_W-1:0]    rspSlot,
  output logic                 relError
);
  logic impossible, fits, anyFree, doRefuse, badFree;
  logic [REQ_THR_W-1:0] freeThrW;
  logic [COST_W-1:0]    freeRegW;

  assign freeThrW = REQ_THR_W'(freeThreads);
  assign freeRegW = COST_W'(freeRegs);

  // Lowest free slot
  always_comb begin
    grantSlot = '0;
    anyFree   = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!busyMask[i] && !anyFree) begin
        grantSlot = SLOT_W'(i);
        anyFree   = 1'b1;
      end
    end
  end

  always_comb begin
    impossible = (reqThreads == '0)
              || (reqThreads > REQ_THR_W'(MAX_THREADS))
              || (reqCost > COST_W'(REG_POOL));
    fits       = anyFree && !impossible
              && (reqThreads <= freeThrW)
              && (reqCost <= freeRegW);
    reqReady   = impossible || fits;
    st.doAdmit = reqValid && fits;
    doRefuse   = reqValid && impossible;
    st.doFree  = relValid && busyMask[relSlot];
    badFree    = relValid && !busyMask[relSlot];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= 1'b0;
      rspSlot  <= '0;
      relError <= 1'b0;
    end else begin
      rspValid <= st.doAdmit || doRefuse;
      rspGrant <= st.doAdmit;
      rspSlot  <= st.doAdmit ? grantSlot : '0;
      relError <= badFree;
    end
  end
endmodule

// File: rtl/blk_admit.sv
module blk_admit
  import blk_admit_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int MAX_THREADS = 768,
  parameter int REG_POOL    = 8192,
  parameter int REQ_THR_W   = 11,
  parameter int REG_PER_W   = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int POOL_W = $clog2(REG_POOL + 1),
  localparam int COST_W = REQ_THR_W + REG_PER_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [REQ_THR_W-1:0] reqThreads,
  input  logic [REG_PER_W-1:0] reqRegs,
  output logic                 rspValid,
  output logic                 rspGrant,
  output logic [SLOT_W-1:0]    rspSlot,
  input  logic                 relValid,
  input  logic [SLOT_W-1:0]    relSlot,
  output logic                 relError
);
  ctlStrobe_t           st;
  logic [SLOT_W-1:0]    grantSlot;
  logic [COST_W-1:0]    reqCost;
  logic [NUM_SLOTS-1:0] busyMask;
  logic [THR_W-1:0]     freeThreads;
  logic [POOL_W-1:0]    freeRegs;

  blk_admit_ctl #(
    .NUM_SLOTS(NUM_SLOTS), .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL),
    .REQ_THR_W(REQ_THR_W), .REG_PER_W(REG_PER_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThreads(reqThreads),
    .reqCost(reqCost), .relValid(relValid), .relSlot(relSlot),
    .busyMask(busyMask), .freeThreads(freeThreads), .freeRegs(freeRegs),
    .reqReady(reqReady), .st(st), .grantSlot(grantSlot),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspSlot(rspSlot),
    .relError(relError)
  );

  blk_admit_dp #(
    .NUM_SLOTS(NUM_SLOTS), .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL),
    .REQ_THR_W(REQ_THR_W), .REG_PER_W(REG_PER_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .grantSlot(grantSlot),
    .relSlot(relSlot), .reqThreads(reqThreads), .reqRegs(reqRegs),
    .reqCost(reqCost), .busyMask(busyMask), .freeThreads(freeThreads),
    .freeRegs(freeRegs)
  );
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int NUM_SLOTS   = 8,
  parameter int MAX_THREADS = 768,
  parameter int REG_POOL    = 8192,
  parameter int REQ_THR_W   = 11,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int POOL_W = $clog2(REG_POOL + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [REQ_THR_W-1:0] reqThreads,
  input logic                 rspValid,
  input logic                 rspGrant,
  input logic [SLOT_W-1:0]    rspSlot,
  input logic                 relValid,
  input logic [SLOT_W-1:0]    relSlot,
  input logic                 relError,
  input logic [NUM_SLOTS-1:0] busyMask,
  input logic [THR_W-1:0]     freeThreads,
  input logic [POOL_W-1:0]    freeRegs
);
  logic [NUM_SLOTS-1:0] prevBusy;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevBusy <= '0;
    else       prevBusy <= busyMask;
  end

  AST_TAKEN_GETS_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid); // R2
  AST_NO_RESPONSE_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid); // R10
  AST_THREAD_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    freeThreads <= THR_W'(MAX_THREADS)); // R3
  AST_REG_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    freeRegs <= POOL_W'(REG_POOL)); // R4
  AST_OVERSIZE_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqThreads > REQ_THR_W'(MAX_THREADS) |=> rspValid && !rspGrant); // R7
  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspGrant |-> !prevBusy[rspSlot] && busyMask[rspSlot]); // R6
  AST_FULL_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (&busyMask) && reqValid && reqReady |=> !rspGrant); // R5
  AST_BAD_RELEASE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    relValid && !busyMask[relSlot] |=> relError); // R9
endmodule

bind blk_admit blk_admit_chk #(
  .NUM_SLOTS(NUM_SLOTS), .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL),
  .REQ_THR_W(REQ_THR_W)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqThreads(reqThreads), .rspValid(rspValid), .rspGrant(rspGrant),
  .rspSlot(rspSlot), .relValid(relValid), .relSlot(relSlot),
  .relError(relError), .busyMask(busyMask), .freeThreads(freeThreads),
  .freeRegs(freeRegs)
);

// File: tb/sim_blk_admit.sv
`timescale 1ns/1ps
module sim_blk_admit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [10:0] reqThreads = '0;
  logic [7:0]  reqRegs = '0;
  logic        rspValid, rspGrant;
  logic [2:0]  rspSlot;
  logic        relValid = 1'b0;
  logic [2:0]  relSlot = '0;
  logic        relError;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  blk_admit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqThreads(reqThreads), .reqRegs(reqRegs), .rspValid(rspValid),
    .rspGrant(rspGrant), .rspSlot(rspSlot), .relValid(relValid),
    .relSlot(relSlot), .relError(relError)
  );

  typedef struct packed {
    logic        isRel;
    logic [10:0] thr;
    logic [7:0]  rg;
    logic [2:0]  slot;
    logic        expReady;
    logic        expGrant;
    logic        expErr;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 11'd256, 8'd10, 3'd0, 1'b1, 1'b1, 1'b0}, // R2 R6
    '{1'b0, 11'd256, 8'd10, 3'd1, 1'b1, 1'b1, 1'b0}, // R2
    '{1'b0, 11'd256, 8'd10, 3'd2, 1'b1, 1'b1, 1'b0}, // R2 thread budget now 0
    '{1'b0, 11'd16,  8'd1,  3'd0, 1'b0, 1'b0, 1'b0}, // R3 threads short
    '{1'b1, 11'd0,   8'd0,  3'd1, 1'b0, 1'b0, 1'b0}, // R8 free slot 1
    '{1'b0, 11'd256, 8'd11, 3'd1, 1'b1, 1'b1, 1'b0}, // R4 cost 2816 fits 3072
    '{1'b1, 11'd0,   8'd0,  3'd5, 1'b0, 1'b0, 1'b1}, // R9 slot 5 unused
    '{1'b0, 11'd1024,8'd1,  3'd0, 1'b1, 1'b0, 1'b0}, // R7 too many threads
    '{1'b0, 11'd0,   8'd4,  3'd0, 1'b1, 1'b0, 1'b0}, // R7 zero threads
    '{1'b1, 11'd0,   8'd0,  3'd0, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b1, 11'd0,   8'd0,  3'd1, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b1, 11'd0,   8'd0,  3'd2, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b0, 11'd200, 8'd41, 3'd0, 1'b1, 1'b0, 1'b0}, // R7 cost 8200
    '{1'b0, 11'd64,  8'd64, 3'd0, 1'b1, 1'b1, 1'b0}, // R4 cost 4096
    '{1'b0, 11'd64,  8'd64, 3'd1, 1'b1, 1'b1, 1'b0}, // R4 pool now 0
    '{1'b0, 11'd1,   8'd1,  3'd0, 1'b0, 1'b0, 1'b0}, // R4 registers short
    '{1'b1, 11'd0,   8'd0,  3'd0, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b1, 11'd0,   8'd0,  3'd1, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b0, 11'd16,  8'd4,  3'd0, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 11'd16,  8'd4,  3'd1, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 11'd16,  8'd4,  3'd2, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 11'd16,  8'd4,  3'd3, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 11'd16,  8'd4,  3'd4, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 11'd16,  8'd4,  3'd5, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 11'd16,  8'd4,  3'd6, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 11'd16,  8'd4,  3'd7, 1'b1, 1'b1, 1'b0}, // R5 all slots taken
    '{1'b0, 11'd16,  8'd4,  3'd0, 1'b0, 1'b0, 1'b0}, // R5 ninth block waits
    '{1'b1, 11'd0,   8'd0,  3'd3, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b0, 11'd16,  8'd4,  3'd3, 1'b1, 1'b1, 1'b0}  // R6 lowest free is 3
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReq(input int thr, input int rg, input bit eRdy,
                       input bit eGrant, input int eSlot, input string tag);
    reqValid = 1'b1;
    reqThreads = 11'(thr);
    reqRegs = 8'(rg);
    #1;
    check(reqReady == eRdy, {tag, " ready"}, int'(reqReady), int'(eRdy));
    @(posedge clk);
    @(negedge clk);
    check(rspValid == eRdy, {tag, " rspValid"}, int'(rspValid), int'(eRdy));
    if (eRdy) begin
      check(rspGrant == eGrant, {tag, " rspGrant"}, int'(rspGrant), int'(eGrant));
      if (eGrant)
        check(int'(rspSlot) == eSlot, {tag, " rspSlot"}, int'(rspSlot), eSlot);
    end
    reqValid = 1'b0;
  endtask

  task automatic doRel(input int slot, input bit eErr, input string tag);
    relValid = 1'b1;
    relSlot = 3'(slot);
    @(posedge clk);
    @(negedge clk);
    check(relError == eErr, {tag, " relError"}, int'(relError), int'(eErr));
    check(rspValid == 1'b0, {tag, " no response"}, int'(rspValid), 0);
    relValid = 1'b0;
  endtask

  initial begin
    #(4 * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rspValid == 1'b0, "R1 rspValid", int'(rspValid), 0);
    check(relError == 1'b0, "R1 relError", int'(relError), 0);
    reqThreads = 11'd768;
    reqRegs = 8'd10;
    #1;
    check(reqReady == 1'b1, "R1 full budget ready", int'(reqReady), 1);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRel)
        doRel(int'(VECS[i].slot), VECS[i].expErr, $sformatf("vector %0d", i));
      else
        doReq(int'(VECS[i].thr), int'(VECS[i].rg), VECS[i].expReady,
              VECS[i].expGrant, int'(VECS[i].slot), $sformatf("vector %0d", i));
    end

    for (int s = 0; s < 8; s++) doRel(s, 1'b0, "R8 drain");

    // R10 / R11: pending request meets a same-cycle release
    doReq(512, 1, 1'b1, 1'b1, 0, "R2 first half");
    reqValid = 1'b1;
    reqThreads = 11'd512;
    reqRegs = 8'd1;
    #1;
    check(reqReady == 1'b0, "R10 held low", int'(reqReady), 0);
    @(posedge clk);
    @(negedge clk);
    check(rspValid == 1'b0, "R10 no response while waiting", int'(rspValid), 0);
    relValid = 1'b1;
    relSlot = 3'd0;
    #1;
    check(reqReady == 1'b0, "R11 release not yet counted", int'(reqReady), 0);
    @(posedge clk);
    @(negedge clk);
    relValid = 1'b0;
    check(relError == 1'b0, "R8 release ok", int'(relError), 0);
    check(rspValid == 1'b0, "R11 no response on release edge", int'(rspValid), 0);
    #1;
    check(reqReady == 1'b1, "R8 freed budget seen", int'(reqReady), 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid && rspGrant, "R10 granted after wait", int'(rspGrant), 1);
    check(rspSlot == 3'd0, "R6 reused slot 0", int'(rspSlot), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule